// File: doc/BRIEF.md
# Bus Fault, Retry and Halt Controller

This block sequences the external bus cycles of a simple bus master and decides what happens when a cycle does not end normally. The internal core presents one cycle at a time on a request interface: address, function code, size, direction, write data and a lock flag. The block latches the request, drives the strobes, and waits for a data acknowledge, a bus-error input, a halt input or a bus request from another master.

The block decides the outcome from the combination of the synchronised bus-error, halt and bus-request inputs. Bus-error alone ends the cycle with a one-clock fault pulse to the core. Bus-error with halt gives a retry of the saved cycle. Bus-error with halt and bus request first hands the bus away and reruns the cycle later. Halt alone stops activity at the next cycle boundary, which also allows single-step operation.

A second bus error arriving before the core reports that its fault handling has finished locks the block up. In that state it drives its halt output low until reset. While a locked read-modify-write sequence is in progress, the bus is never handed to another master.

Top module: `bus_fault_ctrl`

## Requirements
- R1: While and after reset, until a request arrives: as_no, ds_no, bg_no, halt_no and rmc_no are high; data_oe_o, done_o and fault_o are low.
- R2: A read cycle that sees dack_ni low, with bus-error and halt negated, ends with a one-clock done_o pulse. rdata_o then holds the data_i value sampled with the acknowledge. While as_no is low, addr_o, fc_o and size_o carry the requested values and rw_o is 1 (1 = read, 0 = write). done_o and fault_o are never high together.
- R3: During a write cycle, rw_o is 0, data_oe_o is 1 and data_o equals the requested write data.
- R4: A bus error with halt negated, outside the exception window, ends the cycle with strobes inactive and gives a one-clock fault_o pulse and no done_o. fault_locked_o is 1 with that pulse exactly when the faulting cycle was locked.
- R5: Bus-error together with halt ends the cycle with strobes inactive and no fault pulse. No cycle starts while either input stays asserted. The retry drives the same address, function code, size, direction and write data.
- R6: The retried cycle begins (as_no low) at the fourth rising clock edge after both bus-error and halt are negated. This is two synchroniser stages plus a retry wait of RETRY_DLY = 2 clocks.
- R7: Bus request with bus-error and halt, on an unlocked cycle, drives bg_no low with strobes inactive. After bus request is negated, the saved cycle is rerun with the same address. Bus request in an idle, unlocked state also gives the bus away.
- R8: rmc_no goes low when a locked request is accepted and stays low until an unlocked request is accepted, including through retries. While rmc_no is low, bg_no stays high whatever the bus request input does.
- R9: Halt alone lets the current cycle run to its acknowledge. After that, as_no is high, data_oe_o is low, addr_o and rw_o keep their values, and no new cycle starts while halt stays asserted.
- R10: With a request pending and halt asserted, negating halt for a single clock lets exactly one bus cycle run.
- R11: A bus error with halt negated, after a fault_o pulse and before exc_done_i has been pulsed, drives halt_no low. The block then stays with strobes inactive and starts no cycle until reset.
- R12: A pulse on exc_done_i closes the exception window, so the next bus error is an ordinary fault (R4) with halt_no still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core requests a bus cycle (held until as_no falls) |
| req_addr_i | input | AW | Requested address |
| req_fc_i | input | 3 | Requested function code |
| req_size_i | input | 2 | Requested transfer size |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DW | Write data |
| req_lock_i | input | 1 | Cycle belongs to a locked read-modify-write sequence |
| exc_done_i | input | 1 | Core finished handling the last fault |
| done_o | output | 1 | One-clock pulse: cycle completed normally |
| rdata_o | output | DW | Data captured by the last read |
| fault_o | output | 1 | One-clock pulse: cycle ended in a bus error |
| fault_locked_o | output | 1 | With fault_o: faulting cycle was locked |
| as_no | output | 1 | Address strobe, active low |
| ds_no | output | 1 | Data strobe, active low |
| rw_o | output | 1 | Direction, 1 = read |
| addr_o | output | AW | Address of current or last cycle |
| fc_o | output | 3 | Function code of current or last cycle |
| size_o | output | 2 | Size of current or last cycle |
| data_o | output | DW | Write data bus |
| data_oe_o | output | 1 | Data bus output enable |
| data_i | input | DW | Read data bus |
| dack_ni | input | 1 | Data acknowledge, active low |
| berr_ni | input | 1 | Bus error, active low |
| halt_ni | input | 1 | Halt request, active low |
| br_ni | input | 1 | External bus request, active low |
| bg_no | output | 1 | Bus grant, active low |
| halt_no | output | 1 | Double-fault halt indication, active low |
| rmc_no | output | 1 | Locked-sequence indication, active low |

## Verification
The termination inputs are driven in each meaningful combination: acknowledge alone, bus-error alone, bus-error with halt, all three with bus request, the same triple on a locked cycle, and halt alone. Comparing these separates a fault from a retry, a local retry from a rerun after bus release, and a locked cycle from an unlocked one. The retry delay is measured in clock edges from the negation of the inputs. A pending request with a one-clock halt gap tells single-step apart from free running. Two bus errors, one before and one after exc_done_i, separate an ordinary fault from the double-fault lockup.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_WAIT_RETRY,
    ST_BUS_GRANTED,
    ST_STOPPED,
    ST_DOUBLE_FAULT
  } bfc_state_e;
endpackage

// File: rtl/bfc_sync.sv
module bfc_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bfc_hold.sv
module bfc_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  // saved cycle must survive retries and reruns untouched
  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/bfc_seq.sv
module bfc_seq
  import bfc_pkg::*;
#(
  parameter int unsigned RETRY_DLY = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       req_lock_i,
  input  logic       exc_done_i,
  input  logic       berr_i,
  input  logic       halt_i,
  input  logic       br_i,
  input  logic       dack_i,
  output bfc_state_e state_o,
  output logic       load_o,
  output logic       complete_o,
  output logic       done_o,
  output logic       fault_o,
  output logic       fault_locked_o,
  output logic       lock_o
);
  localparam int unsigned CW = (RETRY_DLY < 2) ? 1 : $clog2(RETRY_DLY + 1);

  bfc_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q;
  logic           in_exc_q, rerun_q, lock_q;
  logic           fault_c, set_rerun;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    complete_o = 1'b0;
    fault_c    = 1'b0;
    set_rerun  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (br_i && !lock_q) state_d = ST_BUS_GRANTED;
        else if (req_i) begin
          state_d = ST_ACTIVE;
          load_o  = 1'b1;
        end else if (halt_i) state_d = ST_STOPPED;
      end
      ST_ACTIVE: begin
        if (berr_i && halt_i) begin
          if (br_i && !lock_q) begin
            state_d   = ST_BUS_GRANTED;
            set_rerun = 1'b1;
          end else state_d = ST_WAIT_RETRY;
        end else if (berr_i) begin
          if (in_exc_q) state_d = ST_DOUBLE_FAULT;
          else begin
            fault_c = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (dack_i) begin
          complete_o = 1'b1;
          state_d    = halt_i ? ST_STOPPED : ST_IDLE;
        end
      end
      ST_WAIT_RETRY: begin
        if (!berr_i && !halt_i && cnt_q == CW'(RETRY_DLY - 1)) state_d = ST_ACTIVE;
      end
      ST_BUS_GRANTED: begin
        if (!br_i) state_d = rerun_q ? ST_WAIT_RETRY : ST_IDLE;
      end
      ST_STOPPED: begin
        if (!halt_i) state_d = ST_IDLE;
      end
      ST_DOUBLE_FAULT: state_d = ST_DOUBLE_FAULT;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      cnt_q          <= '0;
      in_exc_q       <= 1'b0;
      rerun_q        <= 1'b0;
      lock_q         <= 1'b0;
      done_o         <= 1'b0;
      fault_o        <= 1'b0;
      fault_locked_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT_RETRY && !berr_i && !halt_i && state_d == ST_WAIT_RETRY)
        cnt_q <= cnt_q + CW'(1);
      else
        cnt_q <= '0;
      if (fault_c)         in_exc_q <= 1'b1;
      else if (exc_done_i) in_exc_q <= 1'b0;
      if (set_rerun) rerun_q <= 1'b1;
      else if (state_q == ST_BUS_GRANTED && !br_i) rerun_q <= 1'b0;
      if (load_o) lock_q <= req_lock_i;
      done_o         <= complete_o;
      fault_o        <= fault_c;
      fault_locked_o <= fault_c & lock_q;
    end
  end

  assign state_o = state_q;
  assign lock_o  = lock_q;

  p_fault_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  p_done_fault_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  p_retry_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_RETRY && (berr_i || halt_i)) |=> state_q != ST_ACTIVE);
  p_no_release_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && state_q != ST_BUS_GRANTED) |=> state_q != ST_BUS_GRANTED);
  p_df_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DOUBLE_FAULT |=> state_q == ST_DOUBLE_FAULT);
endmodule

// File: rtl/bus_fault_ctrl.sv
module bus_fault_ctrl
  import bfc_pkg::*;
#(
  parameter int unsigned AW        = 24,
  parameter int unsigned DW        = 16,
  parameter int unsigned RETRY_DLY = 2,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [2:0]    req_fc_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          req_lock_i,
  input  logic          exc_done_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          fault_o,
  output logic          fault_locked_o,
  output logic          as_no,
  output logic          ds_no,
  output logic          rw_o,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    fc_o,
  output logic [1:0]    size_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [DW-1:0] data_i,
  input  logic          dack_ni,
  input  logic          berr_ni,
  input  logic          halt_ni,
  input  logic          br_ni,
  output logic          bg_no,
  output logic          halt_no,
  output logic          rmc_no
);
  localparam int unsigned HW = AW + 3 + 2 + 1 + DW;

  logic [2:0]    raw_n, sync_n;
  logic          berr_s, halt_s, br_s;
  logic [HW-1:0] hold_d, hold_q;
  logic          load, complete, lock, wr_q;
  bfc_state_e    state;

  assign raw_n = {br_ni, halt_ni, berr_ni};

  bfc_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_n),
    .q_o   (sync_n)
  );

  assign berr_s = ~sync_n[0];
  assign halt_s = ~sync_n[1];
  assign br_s   = ~sync_n[2];

  assign hold_d = {req_addr_i, req_fc_i, req_size_i, req_write_i, req_wdata_i};

  bfc_hold #(.W(HW)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .d_i   (hold_d),
    .q_o   (hold_q)
  );

  assign {addr_o, fc_o, size_o, wr_q, data_o} = hold_q;

  bfc_seq #(.RETRY_DLY(RETRY_DLY)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .req_lock_i    (req_lock_i),
    .exc_done_i    (exc_done_i),
    .berr_i        (berr_s),
    .halt_i        (halt_s),
    .br_i          (br_s),
    .dack_i        (~dack_ni),
    .state_o       (state),
    .load_o        (load),
    .complete_o    (complete),
    .done_o        (done_o),
    .fault_o       (fault_o),
    .fault_locked_o(fault_locked_o),
    .lock_o        (lock)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_o <= '0;
    else if (complete && !wr_q)  rdata_o <= data_i;
  end

  assign as_no     = (state != ST_ACTIVE);
  assign ds_no     = (state != ST_ACTIVE);
  assign data_oe_o = (state == ST_ACTIVE) && wr_q;
  assign rw_o      = ~wr_q;
  assign bg_no     = (state != ST_BUS_GRANTED);
  assign halt_no   = (state != ST_DOUBLE_FAULT);
  assign rmc_no    = ~lock;
endmodule

// File: tb/bus_fault_ctrl_bench.sv
module bus_fault_ctrl_bench;
  typedef struct packed {
    logic        kind;  // 1 = fault, 0 = done
    logic        chk;
    logic [15:0] val;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_write_i = 1'b0, req_lock_i = 1'b0, exc_done_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [2:0]  req_fc_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [15:0] req_wdata_i = '0, data_i = '0;
  logic        dack_ni = 1'b1, berr_ni = 1'b1, halt_ni = 1'b1, br_ni = 1'b1;
  logic        done_o, fault_o, fault_locked_o, as_no, ds_no, rw_o, data_oe_o;
  logic        bg_no, halt_no, rmc_no;
  logic [15:0] rdata_o, data_o;
  logic [23:0] addr_o;
  logic [2:0]  fc_o;
  logic [1:0]  size_o;

  int   checks = 0, errors = 0, done_cnt = 0;
  exp_t exp_q[$];
  exp_t it;

  always #4 clk = ~clk;

  bus_fault_ctrl u_bus_fault_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_fc_i(req_fc_i), .req_size_i(req_size_i), .req_write_i(req_write_i),
    .req_wdata_i(req_wdata_i), .req_lock_i(req_lock_i), .exc_done_i(exc_done_i),
    .done_o(done_o), .rdata_o(rdata_o), .fault_o(fault_o),
    .fault_locked_o(fault_locked_o), .as_no(as_no), .ds_no(ds_no), .rw_o(rw_o),
    .addr_o(addr_o), .fc_o(fc_o), .size_o(size_o), .data_o(data_o),
    .data_oe_o(data_oe_o), .data_i(data_i), .dack_ni(dack_ni), .berr_ni(berr_ni),
    .halt_ni(halt_ni), .br_ni(br_ni), .bg_no(bg_no), .halt_no(halt_no),
    .rmc_no(rmc_no)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected completions
  always @(negedge clk) begin
    if (rst_ni && (done_o || fault_o)) begin
      if (done_o) done_cnt++;
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected completion", {done_o, fault_o}, 0);
      else begin
        it = exp_q.pop_front();
        chk(it.kind == fault_o, "R4 completion kind", 32'(fault_o), 32'(it.kind));
        if (it.kind)
          chk(fault_locked_o == it.val[0], "R4 fault locked flag", 32'(fault_locked_o), 32'(it.val[0]));
        else if (it.chk)
          chk(rdata_o == it.val, "R2 read data", 32'(rdata_o), 32'(it.val));
      end
    end
  end

  task automatic issue(input logic [23:0] a, input logic wr, input logic [15:0] wd,
                       input logic lk);
    @(negedge clk);
    req_addr_i = a; req_write_i = wr; req_wdata_i = wd; req_lock_i = lk;
    req_fc_i = a[2:0]; req_size_i = a[4:3]; req_i = 1'b1;
    do @(negedge clk); while (as_no);
    req_i = 1'b0;
  endtask

  task automatic ack(input logic [15:0] rd, input logic rd_chk);
    exp_q.push_back('{kind: 1'b0, chk: rd_chk, val: rd});
    dack_ni = 1'b0; data_i = rd;
    @(negedge clk);
    dack_ni = 1'b1;
  endtask

  task automatic release_lines();
    berr_ni = 1'b1; halt_ni = 1'b1; br_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(as_no && ds_no && bg_no && halt_no && rmc_no, "R1 strobes in reset",
        {as_no, ds_no, bg_no, halt_no, rmc_no}, 5'h1f);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!data_oe_o && !done_o && !fault_o && as_no, "R1 idle after reset",
        {data_oe_o, done_o, fault_o, as_no}, 4'b0001);

    // R2 read
    issue(24'h12345A, 1'b0, 16'h0, 1'b0);
    chk(addr_o == 24'h12345A && fc_o == 3'h2 && size_o == 2'h3 && rw_o,
        "R2 read cycle attributes", {addr_o, fc_o, size_o}, {24'h12345A, 3'h2, 2'h3});
    ack(16'hBEEF, 1'b1);
    @(negedge clk);
    chk(as_no, "R2 strobe released", 32'(as_no), 1);

    // R3 write
    issue(24'h000100, 1'b1, 16'hC0DE, 1'b0);
    chk(!rw_o && data_oe_o && data_o == 16'hC0DE, "R3 write drive",
        {rw_o, data_oe_o, data_o}, {2'b01, 16'hC0DE});
    ack(16'h0, 1'b0);

    // R5/R6 retry
    issue(24'hA5A508, 1'b1, 16'h1357, 1'b0);
    berr_ni = 1'b0; halt_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(as_no && ds_no, "R5 strobes off on retry", {as_no, ds_no}, 2'b11);
    repeat (5) @(negedge clk);
    chk(as_no && fault_o == 1'b0, "R5 no cycle while held", 32'(as_no), 1);
    berr_ni = 1'b1; halt_ni = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (as_no && n < 20);
    chk(n == 4, "R6 retry delay edges", n, 4);
    chk(addr_o == 24'hA5A508 && data_o == 16'h1357 && !rw_o && data_oe_o &&
        fc_o == 3'h0 && size_o == 2'h1, "R5 retry same cycle",
        {addr_o, data_o}, {24'hA5A508, 16'h1357});
    ack(16'h0, 1'b0);

    // R7 rerun after bus release
    issue(24'h0F0F10, 1'b0, 16'h0, 1'b0);
    br_ni = 1'b0; berr_ni = 1'b0; halt_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bg_no && as_no, "R7 bus granted", {bg_no, as_no}, 2'b01);
    berr_ni = 1'b1; halt_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk(!bg_no && as_no, "R7 held while requested", {bg_no, as_no}, 2'b01);
    br_ni = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (as_no && n < 20);
    chk(!as_no && bg_no && addr_o == 24'h0F0F10, "R7 rerun address",
        {as_no, addr_o}, {1'b0, 24'h0F0F10});
    ack(16'h7E57, 1'b1);

    // R8 locked retry, no release
    issue(24'h222220, 1'b0, 16'h0, 1'b1);
    chk(!rmc_no, "R8 lock asserted", 32'(rmc_no), 0);
    br_ni = 1'b0; berr_ni = 1'b0; halt_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(bg_no && as_no && !rmc_no, "R8 no grant while locked",
        {bg_no, as_no, rmc_no}, 3'b110);
    berr_ni = 1'b1; halt_ni = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (as_no && n < 20);
    chk(!as_no && !rmc_no && bg_no && addr_o == 24'h222220, "R8 locked retry",
        {as_no, rmc_no, bg_no}, 3'b001);
    ack(16'h4242, 1'b1);
    repeat (5) @(negedge clk);
    chk(bg_no && !rmc_no, "R8 idle lock blocks grant", {bg_no, rmc_no}, 2'b10);
    issue(24'h333330, 1'b0, 16'h0, 1'b0);
    chk(rmc_no, "R8 unlocked request clears lock", 32'(rmc_no), 1);
    ack(16'h0, 1'b0);
    repeat (2) @(negedge clk);
    chk(!bg_no, "R7 idle grant", 32'(bg_no), 0);
    release_lines();
    chk(bg_no, "R7 bus returned", 32'(bg_no), 1);

    // R9 halt alone
    issue(24'h444448, 1'b1, 16'h9999, 1'b0);
    halt_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!as_no, "R9 cycle runs under halt", 32'(as_no), 0);
    ack(16'h0, 1'b0);
    chk(as_no && !data_oe_o && addr_o == 24'h444448 && !rw_o, "R9 stopped state",
        {as_no, data_oe_o, rw_o, addr_o}, {3'b100, 24'h444448});
    req_addr_i = 24'h555550; req_write_i = 1'b0; req_lock_i = 1'b0; req_i = 1'b1;
    dack_ni = 1'b0; data_i = 16'h5A5A;
    repeat (6) @(negedge clk);
    chk(as_no, "R9 no new cycle while halted", 32'(as_no), 1);

    // R10 single step
    n = done_cnt;
    exp_q.push_back('{kind: 1'b0, chk: 1'b1, val: 16'h5A5A});
    halt_ni = 1'b1;
    @(negedge clk);
    halt_ni = 1'b0;
    repeat (20) @(negedge clk);
    chk(done_cnt - n == 1, "R10 single step count", done_cnt - n, 1);
    req_i = 1'b0; dack_ni = 1'b1;
    release_lines();

    // R4 fault on locked cycle
    issue(24'h666660, 1'b1, 16'h1111, 1'b1);
    exp_q.push_back('{kind: 1'b1, chk: 1'b1, val: 16'h1});
    berr_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(as_no && halt_no, "R4 fault ends cycle", {as_no, halt_no}, 2'b11);
    release_lines();
    exc_done_i = 1'b1;
    @(negedge clk);
    exc_done_i = 1'b0;

    // R12 fresh fault after handling
    issue(24'h777770, 1'b0, 16'h0, 1'b0);
    exp_q.push_back('{kind: 1'b1, chk: 1'b1, val: 16'h0});
    berr_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(halt_no && as_no, "R12 ordinary fault", {halt_no, as_no}, 2'b11);
    release_lines();

    // R11 double fault
    issue(24'h888880, 1'b0, 16'h0, 1'b0);
    berr_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!halt_no && as_no, "R11 double fault halt", {halt_no, as_no}, 2'b01);
    berr_ni = 1'b1;
    req_i = 1'b1;
    repeat (8) @(negedge clk);
    chk(!halt_no && as_no && bg_no, "R11 lockup persists", {halt_no, as_no, bg_no}, 3'b011);
    req_i = 1'b0;

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule